// File: doc/BRIEF.md
# Low-Side Gate Blanking and Minimum-Pulse Inserter

This block sits between the PWM modulator of a synchronous step-down converter and the low-side gate driver. It passes the low-side gate request through one register stage. It also watches whether each switching period produced a low-side pulse long enough for the current sense to work. Current is sensed across the low-side switch, so at high duty cycle the low-side pulse can become too short to sample, or it can vanish. When two periods in a row are short, the block forces a pulse of guaranteed minimum width in the third period. This keeps overcurrent checking alive at least once every three periods.

A second function qualifies the overcurrent comparator. A sense window opens only after the driven low-side gate has been high for a programmable blanking interval, so that switching noise on the sense node has settled. The window closes as soon as the gate falls. A comparator hit inside the window produces a single-cycle trip pulse, and there is at most one such pulse per low-side pulse.

All times are counted in system clock cycles. At 125 MHz the defaults give 25 cycles of blanking (200 ns) and a 54-cycle minimum pulse (432 ns, just above 425 ns). A new switching period begins in each cycle in which the one-cycle period-start strobe is sampled high. The strobe comes from the 600 kHz oscillator, which gives about 208 system cycles per period.

Top module: `lsg_min_pulse`

## Requirements
- R1: While `rst` is high, or in the cycle after `en` is sampled low, `ls_gate` and `oc_trip` are 0. Disabling also clears all period history, so the first period after enable is treated as following an adequate one.
- R2: While enabled, `ls_gate` in cycle t+1 is high whenever `ls_req` was high in cycle t.
- R3: A period starts in the cycle in which `cyc_start` is sampled high. A period is adequate if, within it, `ls_req` stays high for at least MIN_CYC consecutive cycles. Fewer cycles, including none, make the period narrow, so 54 cycles is adequate and 53 is narrow.
- R4: When two consecutive periods have been narrow and none of them was forced, the next period is forced. In a forced period, `ls_gate` is high for exactly MIN_CYC consecutive cycles, starting in the cycle after the period's `cyc_start` is sampled. During that time it is ORed with the delayed request.
- R5: The narrow-period count returns to zero after any adequate period and after any forced period. The partial period before the first `cyc_start` following reset counts as adequate.
- R6: A high `oc_cmp` is qualified only in a cycle where `ls_gate` has already been high for more than BLANK_CYC consecutive cycles, counting that cycle. Comparator activity during blanking produces no trip.
- R7: A qualified comparator sample raises `oc_trip` for exactly one cycle, in the following cycle. There is at most one trip per `ls_gate` pulse.
- R8: A high `oc_cmp` in cycles where `ls_gate` is low produces no trip. When the gate falls the window closes, and it opens again only with the next gate pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable; low holds the gate off and clears history |
| cyc_start | input | 1 | One-cycle strobe marking the start of a switching period |
| ls_req | input | 1 | Low-side gate request from the PWM modulator |
| oc_cmp | input | 1 | Raw overcurrent comparator output |
| ls_gate | output | 1 | Registered low-side gate to the driver |
| oc_trip | output | 1 | Registered single-cycle overcurrent trip pulse |

## Verification
The properties assume that all inputs are synchronous to `clk` and that reset is held for at least one cycle. They assume nothing about how `cyc_start` is spaced. Minimum-width forcing is checked by the reference model rather than by a property, because it depends on the period history.

The stimulus changes inputs only on the falling clock edge. It issues `cyc_start` as a single-cycle strobe at the head of 208-cycle periods. Every request pulse it applies finishes inside its own period, which gives each period's adequacy an unambiguous expected value.

// File: rtl/lsg_pkg.sv
package lsg_pkg;
  // bits needed to hold values 0..max_val
  function automatic int width_for(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/lsg_narrow_track.sv
module lsg_narrow_track #(
  parameter int MIN_CYC      = 54,
  parameter int NARROW_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic req,
  output logic force_on
);
  localparam int RW = lsg_pkg::width_for(MIN_CYC);
  localparam int MW = lsg_pkg::width_for(NARROW_LIMIT);
  localparam logic [RW-1:0] RUN_MAX  = RW'(MIN_CYC);
  localparam logic [MW-1:0] HIT_CNT  = MW'(NARROW_LIMIT - 1);
  localparam logic [RW-1:0] FILL_CNT = RW'(MIN_CYC - 1);

  logic [RW-1:0] run_q, run_n;
  logic          good_q;
  logic [MW-1:0] miss_q, miss_inc;
  logic          forced_q;
  logic [RW-1:0] fcnt_q;
  logic          long_run, hit;

  always_comb begin
    if (!req)
      run_n = '0;
    else if (start)
      run_n = RW'(1);
    else if (run_q == RUN_MAX)
      run_n = run_q;
    else
      run_n = run_q + RW'(1);
    long_run = (run_n >= RUN_MAX);
    // closing period: adequate or forced restarts the count
    miss_inc = (good_q || forced_q) ? '0 : miss_q + MW'(1);
    hit      = start && (miss_inc == HIT_CNT);
    force_on = hit || (fcnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q    <= '0;
      good_q   <= 1'b1;
      miss_q   <= '0;
      forced_q <= 1'b0;
      fcnt_q   <= '0;
    end else begin
      run_q  <= run_n;
      good_q <= start ? long_run : (good_q || long_run);
      if (start) begin
        miss_q   <= miss_inc;
        forced_q <= hit;
      end
      if (hit)
        fcnt_q <= FILL_CNT;
      else if (fcnt_q != '0)
        fcnt_q <= fcnt_q - RW'(1);
    end
  end
endmodule

// File: rtl/lsg_sense_window.sv
module lsg_sense_window #(
  parameter int BLANK_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic gate_nxt,
  input  logic gate_cur,
  input  logic cmp,
  output logic trip
);
  localparam int HW = lsg_pkg::width_for(BLANK_CYC + 1);
  localparam logic [HW-1:0] OPEN_AT = HW'(BLANK_CYC + 1);

  logic [HW-1:0] hcnt_q;
  logic          armed_q;
  logic          trip_q;
  logic          qual;

  // hcnt_q counts cycles gate_cur has been high, current one included
  assign qual = gate_cur && (hcnt_q == OPEN_AT) && cmp && armed_q;
  assign trip = trip_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt_q  <= '0;
      armed_q <= 1'b1;
      trip_q  <= 1'b0;
    end else begin
      if (!gate_nxt)
        hcnt_q <= '0;
      else if (hcnt_q != OPEN_AT)
        hcnt_q <= hcnt_q + HW'(1);
      armed_q <= !gate_cur || (armed_q && !qual);
      trip_q  <= qual;
    end
  end
endmodule

// File: rtl/lsg_min_pulse.sv
module lsg_min_pulse #(
  parameter int BLANK_CYC    = 25,
  parameter int MIN_CYC      = 54,
  parameter int NARROW_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cyc_start,
  input  logic ls_req,
  input  logic oc_cmp,
  output logic ls_gate,
  output logic oc_trip
);
  logic force_on;
  logic gate_n, gate_q;

  lsg_narrow_track #(
    .MIN_CYC      (MIN_CYC),
    .NARROW_LIMIT (NARROW_LIMIT)
  ) u_track (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .start    (cyc_start),
    .req      (ls_req),
    .force_on (force_on)
  );

  assign gate_n = en && (ls_req || force_on);

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate_n;
  end

  lsg_sense_window #(
    .BLANK_CYC (BLANK_CYC)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .gate_nxt (gate_n),
    .gate_cur (gate_q),
    .cmp      (oc_cmp),
    .trip     (oc_trip)
  );

  assign ls_gate = gate_q;
endmodule

// File: rtl/lsg_min_pulse_chk.sv
module lsg_min_pulse_chk #(
  parameter int BLANK_CYC = 25
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic ls_req,
  input logic oc_cmp,
  input logic ls_gate,
  input logic oc_trip
);
  localparam int CW = lsg_pkg::width_for(BLANK_CYC + 1);
  logic [CW-1:0] run_c;

  always_ff @(posedge clk) begin
    if (rst)                            run_c <= '0;
    else if (!ls_gate)                  run_c <= '0;
    else if (run_c != CW'(BLANK_CYC + 1)) run_c <= run_c + CW'(1);
  end

  AST_OFF_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!ls_gate && !oc_trip)); // R1
  AST_REQ_PASSES: assert property (@(posedge clk) disable iff (rst)
    (en && ls_req) |=> ls_gate); // R2
  AST_TRIP_AFTER_BLANK: assert property (@(posedge clk) disable iff (rst)
    oc_trip |-> (run_c > CW'(BLANK_CYC))); // R6
  AST_TRIP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    oc_trip |=> !oc_trip); // R7
  AST_TRIP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    oc_trip |-> ($past(ls_gate) && $past(oc_cmp) && $past(en))); // R8
endmodule

bind lsg_min_pulse lsg_min_pulse_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .ls_req  (ls_req),
  .oc_cmp  (oc_cmp),
  .ls_gate (ls_gate),
  .oc_trip (oc_trip)
);

// File: tb/lsg_min_pulse_test.sv
module lsg_min_pulse_test;
  localparam int BLANK = 25;
  localparam int MINW  = 54;
  localparam int LIMIT = 3;
  localparam int PER   = 208;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic cyc_start = 1'b0, ls_req = 1'b0, oc_cmp = 1'b0;
  logic ls_gate, oc_trip;

  lsg_min_pulse #(.BLANK_CYC(BLANK), .MIN_CYC(MINW), .NARROW_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .en(en), .cyc_start(cyc_start),
    .ls_req(ls_req), .oc_cmp(oc_cmp), .ls_gate(ls_gate), .oc_trip(oc_trip));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  task automatic chk(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // inputs as sampled at the rising edge
  logic s_rst = 1'b1, s_en = 1'b0, s_start = 1'b0, s_req = 1'b0, s_cmp = 1'b0;
  always @(posedge clk) begin
    s_rst <= rst; s_en <= en; s_start <= cyc_start; s_req <= ls_req; s_cmp <= oc_cmp;
  end

  // behavioural reference
  int  m_run, m_narrow, m_fleft, m_hi;
  bit  m_ok, m_fper, m_armed, e_gate, e_trip;
  int  cur_w = 0, wide_cnt = 0, trip_cnt = 0;

  always @(negedge clk) begin
    bit qual, forced;
    if (s_rst || !s_en) begin
      m_run = 0; m_ok = 1; m_narrow = 0; m_fper = 0; m_fleft = 0;
      m_hi = 0; m_armed = 1; e_gate = 0; e_trip = 0;
    end else begin
      qual = e_gate && (m_hi > BLANK) && s_cmp && m_armed;
      m_armed = !e_gate ? 1'b1 : (qual ? 1'b0 : m_armed);
      e_trip = qual;
      if (s_start) begin
        if (m_ok || m_fper) m_narrow = 0; else m_narrow++;
        m_fper = (m_narrow == LIMIT - 1);
        if (m_fper) m_fleft = MINW;
        m_ok = 0; m_run = 0;
      end
      m_run = s_req ? m_run + 1 : 0;
      if (m_run >= MINW) m_ok = 1;
      forced = (m_fleft > 0);
      if (forced) m_fleft--;
      e_gate = s_req || forced;
      m_hi = e_gate ? m_hi + 1 : 0;
    end
    chk(tag, "ls_gate", int'(ls_gate), int'(e_gate));
    chk(tag, "oc_trip", int'(oc_trip), int'(e_trip));
    // observed pulse statistics for directed checks
    if (ls_gate) cur_w++;
    else if (cur_w > 0) begin
      if (cur_w >= MINW) wide_cnt++;
      cur_w = 0;
    end
    if (oc_trip) trip_cnt++;
  end

  task automatic period(int lo_at, int lo_len, int c_from, int c_to);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      cyc_start = (i == 0);
      ls_req    = (i >= lo_at) && (i < lo_at + lo_len);
      oc_cmp    = (i >= c_from) && (i < c_to);
    end
  endtask

  task automatic begin_phase(string t);
    @(negedge clk);
    tag = t; wide_cnt = 0; trip_cnt = 0;
  endtask

  initial begin
    // R1: reset state
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "gate in reset", int'(ls_gate), 0);
    chk("R1", "trip in reset", int'(oc_trip), 0);
    rst = 1'b0;

    // R2: wide pulses pass unchanged
    begin_phase("R2");
    for (int k = 0; k < 3; k++) period(100, 100, -1, -1);
    chk("R2", "wide pulses passed", wide_cnt, 3);

    // R6: comparator only inside blanking
    begin_phase("R6");
    for (int k = 0; k < 3; k++) period(100, 100, 100, 100 + BLANK + 1);
    chk("R6", "trips during blanking", trip_cnt, 0);

    // R7: comparator held through window, one trip per pulse
    begin_phase("R7");
    for (int k = 0; k < 3; k++) period(100, 100, 100 + BLANK + 1, PER);
    chk("R7", "trips per pulse", trip_cnt, 3);

    // R8: comparator only while gate low
    begin_phase("R8");
    for (int k = 0; k < 3; k++) period(100, 100, 201, PER);
    period(100, 100, 0, 101);
    chk("R8", "trips with gate low", trip_cnt, 0);

    // R4: narrow pulses, every third period forced
    begin_phase("R4");
    for (int k = 0; k < 6; k++) period(180, 20, -1, -1);
    chk("R4", "forced pulses among narrow", wide_cnt, 2);

    // R4: absent pulses, inserted ones are sensed
    begin_phase("R4");
    for (int k = 0; k < 6; k++) period(0, 0, 0, PER);
    chk("R4", "inserted pulses", wide_cnt, 2);
    chk("R6", "trips on inserted pulses", trip_cnt, 2);

    // R3/R5: adequacy boundary and count restart
    begin_phase("R5");
    period(140, 60, -1, -1);
    period(140, 20, -1, -1);
    period(140, MINW, -1, -1);
    tag = "R3";
    period(140, MINW - 1, -1, -1);
    period(140, MINW - 1, -1, -1);
    period(140, 0, -1, -1);
    chk("R5", "wide pulses incl one forced", wide_cnt, 3);

    // R1: disable mid pulse, history cleared
    begin_phase("R1");
    period(100, 100, -1, -1);
    @(negedge clk); cyc_start = 1'b1; ls_req = 1'b1;
    repeat (10) begin @(negedge clk); cyc_start = 1'b0; end
    en = 1'b0;
    @(negedge clk); ls_req = 1'b0;
    chk("R1", "gate after disable", int'(ls_gate), 0);
    repeat (20) @(negedge clk);
    en = 1'b1; wide_cnt = 0;
    for (int k = 0; k < 3; k++) period(180, 20, -1, -1);
    chk("R1", "forced after re-enable", wide_cnt, 1);

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule